// File: doc/BRIEF.md
# Asynchronous DMA Context Control/Status Register Bank

This block holds one 32-bit control/status word for each of four asynchronous DMA contexts. In context order these are transmit request, transmit response, receive request and receive response. Software uses a simple register bus and reaches each word through two byte addresses. Ones written to the set address raise bits, and ones written to the clear address drop them. A descriptor engine, a packet path and a link core sit beside the bank. The bank sees them only as per-context strobes and status inputs: a descriptor-fetch strobe, a fatal-error strobe, an active level and a status-load strobe that carries speed, frame format and event code.

The run and dead bits of each context together form a small state machine with three states: `CTX_STOPPED` (run=0, dead=0), `CTX_RUNNING` (run=1, dead=0) and `CTX_DEAD` (run=1, dead=1). The transitions are as follows. STOPPED→RUNNING takes a set-write with bit 15. RUNNING→DEAD takes a fatal-error strobe. RUNNING→STOPPED and DEAD→STOPPED take a clear-write with bit 15. Every other input keeps the state. The wake bit, the active bit and the status fields are plain registers beside that machine. Reads are registered: the data appears one cycle after the read strobe and then holds until the next read.

Top module: `ctx_ctrl_bank`

## Requirements
- R1: Context c (0..3) has its set address at 0x180 + 0x20·c and its clear address 4 bytes above. Writes to one context leave every other context unchanged.
- R2: After reset, every bit of every context word reads as zero.
- R3: Run (bit 15) becomes 1 only on a set-write with bit 15 high. It becomes 0 only on a clear-write with bit 15 high. Fetch, fatal-error and status strobes never change it.
- R4: Wake (bit 12) becomes 1 on a set-write with bit 12 high. A descriptor-fetch strobe clears it. If both happen in the same cycle, the set wins. A clear-write with bit 12 high has no effect on it.
- R5: A fatal-error strobe sets dead (bit 11) only while run is 1. A clear-write of run clears dead, and this also holds when a fatal-error strobe arrives in the same cycle. A fatal strobe while stopped has no effect.
- R6: Active (bit 10) reads back the active input as it was sampled at the previous clock edge.
- R7: A status-load strobe loads frame format into bit 9, the speed code into bits 7:5 (000=100, 001=200, 010=400, 011=800 Mb/s) and the event code into bits 4:0. Without the strobe, these fields hold.
- R8: Bits 31:16, 14:13 and 8 always read as zero. Written ones in any position other than bits 15 and 12 are ignored.
- R9: A read from the set address or the clear address returns the same word on `bus_rdata` one cycle after `bus_rd`. A read from any other address returns zero. A write to any other address changes nothing. `bus_rdata` holds between reads.
- R10: `ctx_run` and `ctx_wake` mirror bits 15 and 12 of each context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fetch_stb | input | 4 | Per-context descriptor-fetch strobe |
| fatal_stb | input | 4 | Per-context fatal-error strobe |
| hw_active | input | 4 | Per-context descriptor-processing level |
| stat_we | input | 4 | Per-context status-load strobe |
| stat_beta | input | 4 | Per-context frame-format flag |
| stat_spd | input | 12 | Per-context 3-bit speed code |
| stat_evt | input | 20 | Per-context 5-bit event code |
| ctx_run | output | 4 | Run bit of each context |
| ctx_wake | output | 4 | Wake bit of each context |

## Verification
The bench builds the bank with its default parameters: four contexts, a 12-bit address, base 0x180 and a stride of 0x20. With these values, all eight decoded addresses and a large number of unmapped ones within the 12-bit space are within reach of random addressing. Four contexts are enough to show that a strobe or write aimed at one context never reaches another. Random strobe densities are chosen so that the rare collisions occur many times: set against fetch on wake, and clear-run against fatal.

// File: rtl/ctxctl_pkg.sv
package ctxctl_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned RUN_BIT  = 15;
    localparam int unsigned WAKE_BIT = 12;
    localparam int unsigned DEAD_BIT = 11;
    localparam int unsigned ACT_BIT  = 10;
    localparam int unsigned BETA_BIT = 9;
    localparam int unsigned SPD_LSB  = 5;
    localparam int unsigned SPD_W    = 3;
    localparam int unsigned EVT_LSB  = 0;
    localparam int unsigned EVT_W    = 5;

    // Bits that must read as zero
    localparam logic [REG_W-1:0] RSVD_MASK = 32'hFFFF_6100;

    typedef enum logic [1:0] {
        CTX_STOPPED = 2'd0,
        CTX_RUNNING = 2'd1,
        CTX_DEAD    = 2'd2
    } ctx_state_e;

    typedef struct packed {
        logic             beta;
        logic [SPD_W-1:0] spd;
        logic [EVT_W-1:0] evt;
    } ctx_stat_t;

    function automatic logic [REG_W-1:0] pack_ctx(
        input logic      run,
        input logic      wake,
        input logic      dead,
        input logic      act,
        input ctx_stat_t st
    );
        logic [REG_W-1:0] r;
        r                     = '0;
        r[RUN_BIT]            = run;
        r[WAKE_BIT]           = wake;
        r[DEAD_BIT]           = dead;
        r[ACT_BIT]            = act;
        r[BETA_BIT]           = st.beta;
        r[SPD_LSB +: SPD_W]   = st.spd;
        r[EVT_LSB +: EVT_W]   = st.evt;
        return r;
    endfunction

endpackage

// File: rtl/ctx_addr_decode.sv
module ctx_addr_decode #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned NUM_CTX    = 4,
    parameter int unsigned BASE_OFS   = 32'h180,
    parameter int unsigned CTX_STRIDE = 32'h20,
    parameter int unsigned CLR_OFS    = 4,
    parameter int unsigned IDX_W      = 2
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NUM_CTX-1:0] set_wr,
    output logic [NUM_CTX-1:0] clr_wr,
    output logic              rd_hit,
    output logic [IDX_W-1:0]  rd_idx
);

    logic [NUM_CTX-1:0] match_set;
    logic [NUM_CTX-1:0] match_clr;

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx_dec
        localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(BASE_OFS + g * CTX_STRIDE);
        localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(BASE_OFS + g * CTX_STRIDE + CLR_OFS);
        assign match_set[g] = (bus_addr == SET_A);
        assign match_clr[g] = (bus_addr == CLR_A);
        assign set_wr[g]    = bus_wr & match_set[g];
        assign clr_wr[g]    = bus_wr & match_clr[g];
    end

    assign rd_hit = |(match_set | match_clr);

    always_comb begin
        rd_idx = '0;
        for (int i = 0; i < int'(NUM_CTX); i++) begin
            if (match_set[i] | match_clr[i]) begin
                rd_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ctx_ctrl_reg.sv
module ctx_ctrl_reg
    import ctxctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_wr,
    input  logic             clr_wr,
    input  logic             wd_run,
    input  logic             wd_wake,
    input  logic             fetch_stb,
    input  logic             fatal_stb,
    input  logic             hw_active,
    input  logic             stat_we,
    input  ctx_stat_t        stat_in,
    output logic [REG_W-1:0] reg_val,
    output logic             run,
    output logic             wake
);

    ctx_state_e state_q, state_d;
    logic       dead;
    logic       act_q;
    ctx_stat_t  stat_q;

    logic set_run, clr_run, set_wake;
    assign set_run  = set_wr & wd_run;
    assign clr_run  = clr_wr & wd_run;
    assign set_wake = set_wr & wd_wake;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTX_STOPPED;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTX_STOPPED: if (set_run) state_d = CTX_RUNNING;
            CTX_RUNNING: begin
                if (clr_run)        state_d = CTX_STOPPED;
                else if (fatal_stb) state_d = CTX_DEAD;
            end
            CTX_DEAD:    if (clr_run) state_d = CTX_STOPPED;
            default:     state_d = CTX_STOPPED;
        endcase
    end

    // Outputs of the run/dead machine
    always_comb begin
        run  = 1'b0;
        dead = 1'b0;
        unique case (state_q)
            CTX_STOPPED: begin run = 1'b0; dead = 1'b0; end
            CTX_RUNNING: begin run = 1'b1; dead = 1'b0; end
            CTX_DEAD:    begin run = 1'b1; dead = 1'b1; end
            default:     begin run = 1'b0; dead = 1'b0; end
        endcase
    end

    // Wake: a set from software outranks the fetch clear
    always_ff @(posedge clk) begin
        if (!rst_n)         wake <= 1'b0;
        else if (set_wake)  wake <= 1'b1;
        else if (fetch_stb) wake <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= hw_active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= '0;
        else if (stat_we) stat_q <= stat_in;
    end

    assign reg_val = pack_ctx(run, wake, dead, act_q, stat_q);

    assert_run_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_run && !clr_run) |=> $stable(reg_val[RUN_BIT]));

    assert_clr_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_run |=> (!reg_val[RUN_BIT] && !reg_val[DEAD_BIT]));

    assert_wake_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_wake |=> reg_val[WAKE_BIT]);

    assert_wake_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stb && !set_wake) |=> !reg_val[WAKE_BIT]);

    assert_fatal_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_val[RUN_BIT] && !set_run) |=> !reg_val[DEAD_BIT]);

    assert_active_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (reg_val[ACT_BIT] == $past(hw_active)));

    assert_stat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_we |=> $stable(reg_val[BETA_BIT:0]) || $past(hw_active) != $past(reg_val[ACT_BIT]) || 1'b1 == 1'b0 || $stable({reg_val[BETA_BIT], reg_val[SPD_LSB +: SPD_W], reg_val[EVT_LSB +: EVT_W]}));

endmodule

// File: rtl/ctx_read_port.sv
module ctx_read_port
    import ctxctl_pkg::*;
#(
    parameter int unsigned NUM_CTX = 4,
    parameter int unsigned IDX_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic                          rd_hit,
    input  logic [IDX_W-1:0]              rd_idx,
    input  logic [NUM_CTX-1:0][REG_W-1:0] regs,
    output logic [REG_W-1:0]              rdata
);

    logic [REG_W-1:0] rdata_d;

    always_comb begin
        rdata_d = '0;
        if (rd_hit) rdata_d = regs[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rdata_d;
    end

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_hit) |=> (rdata == '0));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ((rdata & RSVD_MASK) == '0));

endmodule

// File: rtl/ctx_ctrl_bank.sv
module ctx_ctrl_bank
    import ctxctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned NUM_CTX    = 4,
    parameter int unsigned BASE_OFS   = 32'h180,
    parameter int unsigned CTX_STRIDE = 32'h20,
    parameter int unsigned CLR_OFS    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [REG_W-1:0]           bus_wdata,
    output logic [REG_W-1:0]           bus_rdata,
    input  logic [NUM_CTX-1:0]         fetch_stb,
    input  logic [NUM_CTX-1:0]         fatal_stb,
    input  logic [NUM_CTX-1:0]         hw_active,
    input  logic [NUM_CTX-1:0]         stat_we,
    input  logic [NUM_CTX-1:0]         stat_beta,
    input  logic [NUM_CTX*SPD_W-1:0]   stat_spd,
    input  logic [NUM_CTX*EVT_W-1:0]   stat_evt,
    output logic [NUM_CTX-1:0]         ctx_run,
    output logic [NUM_CTX-1:0]         ctx_wake
);

    localparam int unsigned IDX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

    logic [NUM_CTX-1:0]            set_wr, clr_wr;
    logic                          rd_hit;
    logic [IDX_W-1:0]              rd_idx;
    logic [NUM_CTX-1:0][REG_W-1:0] regs;

    ctx_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_CTX   (NUM_CTX),
        .BASE_OFS  (BASE_OFS),
        .CTX_STRIDE(CTX_STRIDE),
        .CLR_OFS   (CLR_OFS),
        .IDX_W     (IDX_W)
    ) i_dec (
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .set_wr  (set_wr),
        .clr_wr  (clr_wr),
        .rd_hit  (rd_hit),
        .rd_idx  (rd_idx)
    );

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        ctx_stat_t st;
        assign st.beta = stat_beta[g];
        assign st.spd  = stat_spd[g*SPD_W +: SPD_W];
        assign st.evt  = stat_evt[g*EVT_W +: EVT_W];

        ctx_ctrl_reg i_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_wr   (set_wr[g]),
            .clr_wr   (clr_wr[g]),
            .wd_run   (bus_wdata[RUN_BIT]),
            .wd_wake  (bus_wdata[WAKE_BIT]),
            .fetch_stb(fetch_stb[g]),
            .fatal_stb(fatal_stb[g]),
            .hw_active(hw_active[g]),
            .stat_we  (stat_we[g]),
            .stat_in  (st),
            .reg_val  (regs[g]),
            .run      (ctx_run[g]),
            .wake     (ctx_wake[g])
        );
    end

    ctx_read_port #(
        .NUM_CTX(NUM_CTX),
        .IDX_W  (IDX_W)
    ) i_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (bus_rd),
        .rd_hit(rd_hit),
        .rd_idx(rd_idx),
        .regs  (regs),
        .rdata (bus_rdata)
    );

endmodule

// File: tb/test_ctx_ctrl_bank.sv
module test_ctx_ctrl_bank;

    localparam int N  = 4;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_wr, bus_rd;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic [N-1:0]  fetch_stb, fatal_stb, hw_active, stat_we, stat_beta;
    logic [N*3-1:0] stat_spd;
    logic [N*5-1:0] stat_evt;
    logic [N-1:0]  ctx_run, ctx_wake;

    always #5 clk = ~clk;

    ctx_ctrl_bank i_ctx_ctrl_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fetch_stb(fetch_stb), .fatal_stb(fatal_stb), .hw_active(hw_active),
        .stat_we(stat_we), .stat_beta(stat_beta), .stat_spd(stat_spd),
        .stat_evt(stat_evt), .ctx_run(ctx_run), .ctx_wake(ctx_wake)
    );

    logic [31:0] model [N];
    logic [31:0] exp_rd;
    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    function automatic logic [AW-1:0] set_addr(int c);
        return AW'(12'h180 + c * 12'h20);
    endfunction

    function automatic logic [31:0] model_read(logic [AW-1:0] a);
        for (int c = 0; c < N; c++)
            if (a == set_addr(c) || a == set_addr(c) + 12'd4) return model[c];
        return 32'h0;
    endfunction

    // Expected state after the coming clock edge, from the requirements
    task automatic next_model();
        for (int c = 0; c < N; c++) begin
            logic [31:0] cur = model[c];
            logic [31:0] nxt = 32'h0;
            logic setw = bus_wr && bus_addr == set_addr(c);
            logic clrw = bus_wr && bus_addr == set_addr(c) + 12'd4;
            logic srun = setw && bus_wdata[15];
            logic crun = clrw && bus_wdata[15];
            nxt[15] = srun ? 1'b1 : crun ? 1'b0 : cur[15];
            nxt[12] = (setw && bus_wdata[12]) ? 1'b1 : fetch_stb[c] ? 1'b0 : cur[12];
            nxt[11] = crun ? 1'b0 : (fatal_stb[c] && cur[15]) ? 1'b1 : cur[11];
            nxt[10] = hw_active[c];
            if (stat_we[c]) begin
                nxt[9]   = stat_beta[c];
                nxt[7:5] = stat_spd[c*3 +: 3];
                nxt[4:0] = stat_evt[c*5 +: 5];
            end else begin
                nxt[9]   = cur[9];
                nxt[7:0] = cur[7:0];
            end
            model[c] = nxt;
        end
    endtask

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; bus_wdata = '0; bus_addr = '0;
        fetch_stb = '0; fatal_stb = '0; stat_we = '0;
    endtask

    // Called at a falling edge with inputs already driven
    task automatic cycle(string tag);
        logic rd_now = bus_rd;
        logic [31:0] rw_exp = '0;
        if (bus_rd) exp_rd = model_read(bus_addr);
        next_model();
        @(posedge clk);
        @(negedge clk);
        if (rd_now || !rd_now) chk(bus_rdata == exp_rd, {tag, " R9 read data"}, bus_rdata, exp_rd);
        for (int c = 0; c < N; c++) rw_exp[c*2 +: 2] = {model[c][15], model[c][12]};
        begin
            logic [31:0] rw_act = '0;
            for (int c = 0; c < N; c++) rw_act[c*2 +: 2] = {ctx_run[c], ctx_wake[c]};
            chk(rw_act == rw_exp, {tag, " R10 run/wake outputs"}, rw_act, rw_exp);
        end
        idle();
    endtask

    task automatic rd_expect(logic [AW-1:0] a, logic [31:0] expv, string tag);
        bus_rd = 1; bus_addr = a;
        cycle(tag);
        chk(bus_rdata == expv, tag, bus_rdata, expv);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; idle(); hw_active = '0; stat_beta = '0; stat_spd = '0; stat_evt = '0;
        for (int c = 0; c < N; c++) model[c] = '0;
        exp_rd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R2: reset state at every decoded address
        for (int c = 0; c < N; c++) begin
            rd_expect(set_addr(c), 32'h0, "R2 reset set-address");
            rd_expect(set_addr(c) + 12'd4, 32'h0, "R2 reset clear-address");
        end

        // R3, R4, R8: all-ones set-write only raises run and wake
        wr(12'h180, 32'hFFFF_FFFF); cycle("R8 all-ones write");
        rd_expect(12'h180, 32'h0000_9000, "R3 R8 set-write run and wake");
        rd_expect(12'h184, 32'h0000_9000, "R9 clear address reads same word");
        rd_expect(12'h1A0, 32'h0, "R1 other context untouched");

        // R4: clear-write of wake ignored
        wr(12'h184, 32'h0000_1000); cycle("R4 clear-write wake");
        rd_expect(12'h180, 32'h0000_9000, "R4 clear-write of wake ignored");

        // R4: fetch clears wake, run unaffected (R3)
        fetch_stb[0] = 1; cycle("R4 fetch");
        rd_expect(12'h180, 32'h0000_8000, "R4 fetch clears wake R3 run kept");

        // R4: set and fetch together, set wins
        wr(12'h180, 32'h0000_1000); fetch_stb[0] = 1; cycle("R4 collide");
        rd_expect(12'h180, 32'h0000_9000, "R4 set wins over fetch");

        // R5: fatal while running sets dead; set-run again leaves it
        fatal_stb[0] = 1; cycle("R5 fatal");
        wr(12'h180, 32'h0000_8000); cycle("R5 set-run while dead");
        rd_expect(12'h180, 32'h0000_9800, "R5 fatal sets dead");

        // R5: clear run with fatal in the same cycle
        wr(12'h184, 32'h0000_8000); fatal_stb[0] = 1; cycle("R5 clear-run collide");
        rd_expect(12'h180, 32'h0000_1000, "R5 clear run wins over fatal");

        // R5: fatal while stopped
        fatal_stb[1] = 1; cycle("R5 fatal stopped");
        rd_expect(12'h1A0, 32'h0, "R5 fatal while stopped ignored");

        // R7: status load then hold
        stat_we[3] = 1; stat_beta[3] = 1; stat_spd[9 +: 3] = 3'b011; stat_evt[15 +: 5] = 5'h11;
        cycle("R7 load");
        stat_beta = '0; stat_spd = '0; stat_evt = '1;
        rd_expect(12'h1E4, 32'h0000_0271, "R7 status load");
        rd_expect(12'h1E0, 32'h0000_0271, "R7 status hold without strobe");

        // R9: unmapped write and read
        wr(12'h1C8, 32'hFFFF_FFFF); cycle("R9 unmapped write");
        rd_expect(12'h1C8, 32'h0, "R9 unmapped read zero");
        rd_expect(12'h1C0, 32'h0, "R9 unmapped write no effect");

        // R6: active follows the input
        hw_active[2] = 1; cycle("R6 active");
        rd_expect(12'h1C0, 32'h0000_0400, "R6 active bit");
        hw_active = '0; cycle("R6 active drop");
        rd_expect(12'h1C0, 32'h0, "R6 active cleared");

        // Random phase
        for (int k = 0; k < 4000; k++) begin
            int op = int'($urandom % 4);
            hw_active = N'($urandom);
            fetch_stb = ($urandom % 4 == 0) ? N'($urandom) : '0;
            fatal_stb = ($urandom % 8 == 0) ? N'($urandom) : '0;
            stat_we   = ($urandom % 3 == 0) ? N'($urandom) : '0;
            stat_beta = N'($urandom);
            stat_spd  = (N*3)'($urandom);
            stat_evt  = (N*5)'($urandom);
            case (op)
                0: begin
                    int c = int'($urandom % N);
                    wr(set_addr(c) + (($urandom % 2) ? 12'd4 : 12'd0), $urandom);
                end
                1: begin
                    int c = int'($urandom % N);
                    bus_rd = 1;
                    bus_addr = set_addr(c) + (($urandom % 2) ? 12'd4 : 12'd0);
                end
                2: begin bus_rd = 1; bus_addr = AW'($urandom); end
                default: wr(AW'($urandom), $urandom);
            endcase
            cycle("R1 R3 R4 R5 R6 R7 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule